// File: doc/BRIEF.md
# USB Indexed Endpoint Register Bank

This block is the byte-wide register front end of a USB device controller. A simple 8-bit bus with an address, a write strobe and a read strobe reaches a small set of registers. Each start-of-frame strobe from the protocol side carries an 11-bit frame number. The block latches that number into two read-only bytes. Both bytes change in the same clock, so a read never returns a mix of two frames.

An index register selects one of five endpoints. Five per-endpoint bytes appear behind a fixed five-address window, and the index decides which endpoint's bytes they are: IN control/status, OUT control/status, IN max-packet, OUT max-packet and OUT write-count. The same index register holds two global isochronous controls, an auto-flush enable and a deferred-update enable. Both drive output pins to the transmit logic. All endpoint bytes are also brought out as a flat vector for the protocol engine.

Top module: `usb_epr_top`

## Requirements
- R1: After reset, every register reads 0x00, bus_rdata is 0x00, and iso_upd_en, auto_flush_en and ep_cfg are all zero.
- R2: A cycle with sof_stb high loads sof_frame into the frame register. Address 0x56 then reads frame bits 7:0, and address 0x57 reads frame bits 10:8 in its bits 2:0, with bits 7:3 as zero. Both bytes take the new frame in the same clock and hold it until the next strobe.
- R3: Writes to 0x56 and 0x57 have no effect on the frame bytes.
- R4: The index register is at 0x58. A write stores bits 2:0 (endpoint select), bit 6 and bit 7. Written values of bits 5:3 are discarded, and those bits always read as zero.
- R5: iso_upd_en follows index bit 7 and auto_flush_en follows index bit 6, starting in the cycle after the write.
- R6: Addresses 0x50 to 0x54 form the window: IN CSR, OUT CSR, IN max-packet, OUT max-packet and OUT write-count, in that order. With select e in 0..4, a window access reads or writes only endpoint e's byte. ep_cfg exposes endpoint e, register r at bits [(e*5+r)*8 +: 8].
- R7: With select 5, 6 or 7, window writes change nothing and window reads return 0x00.
- R8: Addresses other than 0x50 to 0x58 read 0x00, and writes to them change nothing.
- R9: bus_rdata is registered. It is loaded in the cycle after bus_rd is high, with the value the register held before any write in that same cycle, and it keeps its value when bus_rd is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read data |
| sof_stb | input | 1 | Start-of-frame strobe, one cycle per token |
| sof_frame | input | 11 | Frame number carried by the token |
| iso_upd_en | output | 1 | Deferred isochronous update enable (index bit 7) |
| auto_flush_en | output | 1 | Isochronous auto-flush enable (index bit 6) |
| ep_cfg | output | 200 | All endpoint bytes, endpoint-major |

## Verification
The assertions assume that every input is known once reset is released. They also assume that sof_frame is meaningful in any cycle where sof_stb is high, and that each cycle carries at most one address. In that cycle a read and a write may both target it. The bench drives every input to a defined value at mid-cycle and never leaves the bus floating. Its random phase draws addresses from the mapped set plus a few unmapped ones. It mixes index values from both the valid and the undefined range with strobes that coincide with writes to the frame bytes.

// File: rtl/usb_epr_pkg.sv
package usb_epr_pkg;
  localparam int BUS_W = 8;
  localparam int SEL_W = 3;
  localparam logic [BUS_W-1:0] ADR_WIN_BASE = 8'h50;
  localparam logic [BUS_W-1:0] ADR_FN_LO    = 8'h56;
  localparam logic [BUS_W-1:0] ADR_FN_HI    = 8'h57;
  localparam logic [BUS_W-1:0] ADR_INDEX    = 8'h58;
  localparam int IDX_AUTO_BIT = 6;
  localparam int IDX_ISO_BIT  = 7;
endpackage

// File: rtl/usb_epr_frame.sv
module usb_epr_frame #(
  parameter int FN_W = 11
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sof_stb,
  input  logic [FN_W-1:0] sof_frame,
  output logic [FN_W-1:0] frame_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)       frame_q <= '0;
    else if (sof_stb) frame_q <= sof_frame;
  end
endmodule

// File: rtl/usb_epr_index.sv
module usb_epr_index #(
  parameter int SEL_W  = 3,
  parameter int NUM_EP = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_stb,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic             wr_auto,
  input  logic             wr_iso,
  output logic [SEL_W-1:0] sel_q,
  output logic             auto_q,
  output logic             iso_q,
  output logic             sel_ok
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q  <= '0;
      auto_q <= 1'b0;
      iso_q  <= 1'b0;
    end else if (wr_stb) begin
      sel_q  <= wr_sel;
      auto_q <= wr_auto;
      iso_q  <= wr_iso;
    end
  end

  assign sel_ok = (32'(sel_q) < NUM_EP);
endmodule

// File: rtl/usb_epr_epfile.sv
module usb_epr_epfile #(
  parameter int NUM_EP = 5,
  parameter int NREG   = 5,
  parameter int DW     = 8,
  parameter int SEL_W  = 3,
  localparam int OFS_W = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [SEL_W-1:0]         sel,
  input  logic [OFS_W-1:0]         ofs,
  input  logic [DW-1:0]            wdata,
  output logic [DW-1:0]            rd_byte,
  output logic [NUM_EP*NREG*DW-1:0] cfg_flat
);
  logic [DW-1:0] mem [NUM_EP][NREG];

  for (genvar e = 0; e < NUM_EP; e++) begin : g_ep
    for (genvar r = 0; r < NREG; r++) begin : g_reg
      always_ff @(posedge clk) begin
        if (!rst_n)
          mem[e][r] <= '0;
        else if (wr_en && 32'(sel) == e && 32'(ofs) == r)
          mem[e][r] <= wdata;
      end
      assign cfg_flat[(e*NREG+r)*DW +: DW] = mem[e][r];
    end
  end

  always_comb begin
    rd_byte = '0;
    for (int e = 0; e < NUM_EP; e++)
      for (int r = 0; r < NREG; r++)
        if (32'(sel) == e && 32'(ofs) == r) rd_byte = mem[e][r];
  end
endmodule

// File: rtl/usb_epr_top.sv
module usb_epr_top #(
  parameter int NUM_EP = 5,
  parameter int NREG   = 5,
  parameter int FN_W   = 11,
  localparam int OFS_W = (NREG > 1) ? $clog2(NREG) : 1,
  localparam int CFG_W = NUM_EP * NREG * 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       bus_addr,
  input  logic             bus_wr,
  input  logic [7:0]       bus_wdata,
  input  logic             bus_rd,
  output logic [7:0]       bus_rdata,
  input  logic             sof_stb,
  input  logic [FN_W-1:0]  sof_frame,
  output logic             iso_upd_en,
  output logic             auto_flush_en,
  output logic [CFG_W-1:0] ep_cfg
);
  import usb_epr_pkg::*;

  logic [FN_W-1:0]  frame_q;
  logic [SEL_W-1:0] idx_sel;
  logic             sel_ok;
  logic             in_win;
  logic [OFS_W-1:0] win_ofs;
  logic [7:0]       win_byte;
  logic [7:0]       rd_mux;

  assign in_win  = (bus_addr >= ADR_WIN_BASE) &&
                   (32'(bus_addr) < 32'(ADR_WIN_BASE) + NREG);
  assign win_ofs = OFS_W'(bus_addr - ADR_WIN_BASE);

  usb_epr_frame #(.FN_W(FN_W)) u_frame (
    .clk       (clk),
    .rst_n     (rst_n),
    .sof_stb   (sof_stb),
    .sof_frame (sof_frame),
    .frame_q   (frame_q)
  );

  usb_epr_index #(.SEL_W(SEL_W), .NUM_EP(NUM_EP)) u_index (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_stb  (bus_wr && bus_addr == ADR_INDEX),
    .wr_sel  (bus_wdata[SEL_W-1:0]),
    .wr_auto (bus_wdata[IDX_AUTO_BIT]),
    .wr_iso  (bus_wdata[IDX_ISO_BIT]),
    .sel_q   (idx_sel),
    .auto_q  (auto_flush_en),
    .iso_q   (iso_upd_en),
    .sel_ok  (sel_ok)
  );

  usb_epr_epfile #(.NUM_EP(NUM_EP), .NREG(NREG), .DW(8), .SEL_W(SEL_W)) u_epfile (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (bus_wr && in_win && sel_ok),
    .sel      (idx_sel),
    .ofs      (win_ofs),
    .wdata    (bus_wdata),
    .rd_byte  (win_byte),
    .cfg_flat (ep_cfg)
  );

  always_comb begin
    rd_mux = '0;
    if (bus_addr == ADR_FN_LO)
      rd_mux = frame_q[7:0];
    else if (bus_addr == ADR_FN_HI)
      rd_mux = 8'(frame_q[FN_W-1:8]);
    else if (bus_addr == ADR_INDEX) begin
      rd_mux[SEL_W-1:0]    = idx_sel;
      rd_mux[IDX_AUTO_BIT] = auto_flush_en;
      rd_mux[IDX_ISO_BIT]  = iso_upd_en;
    end else if (in_win && sel_ok)
      rd_mux = win_byte;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/usb_epr_chk.sv
module usb_epr_chk #(
  parameter int NUM_EP = 5,
  parameter int NREG   = 5,
  parameter int FN_W   = 11,
  parameter int CFG_W  = NUM_EP * NREG * 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [7:0]       bus_addr,
  input logic             bus_wr,
  input logic [7:0]       bus_wdata,
  input logic             bus_rd,
  input logic [7:0]       bus_rdata,
  input logic             sof_stb,
  input logic [FN_W-1:0]  sof_frame,
  input logic [FN_W-1:0]  frame_q,
  input logic [2:0]       idx_sel,
  input logic             iso_upd_en,
  input logic             auto_flush_en,
  input logic [CFG_W-1:0] ep_cfg
);
  logic win_hit;
  assign win_hit = (bus_addr >= 8'h50) && (32'(bus_addr) < 32'h50 + NREG);

  AST_FRAME_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    sof_stb |=> frame_q == $past(sof_frame));                              // R2
  AST_FRAME_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !sof_stb |=> $stable(frame_q));                                        // R3
  AST_HI_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == 8'h57) |=> bus_rdata[7:3] == 5'd0);             // R2
  AST_IDX_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == 8'h58) |=> bus_rdata[5:3] == 3'd0);             // R4
  AST_ISO_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 8'h58) |=> iso_upd_en == $past(bus_wdata[7]));  // R5
  AST_AUTO_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 8'h58) |=> auto_flush_en == $past(bus_wdata[6])); // R5
  AST_BAD_IDX_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && win_hit && 32'(idx_sel) >= NUM_EP) |=> $stable(ep_cfg));    // R7
  AST_BAD_IDX_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && win_hit && 32'(idx_sel) >= NUM_EP) |=> bus_rdata == 8'h00); // R7
  AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !win_hit && bus_addr != 8'h56 && bus_addr != 8'h57 && bus_addr != 8'h58)
      |=> bus_rdata == 8'h00);                                             // R8
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));                                       // R9
endmodule

bind usb_epr_top usb_epr_chk #(.NUM_EP(NUM_EP), .NREG(NREG), .FN_W(FN_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .bus_addr      (bus_addr),
  .bus_wr        (bus_wr),
  .bus_wdata     (bus_wdata),
  .bus_rd        (bus_rd),
  .bus_rdata     (bus_rdata),
  .sof_stb       (sof_stb),
  .sof_frame     (sof_frame),
  .frame_q       (frame_q),
  .idx_sel       (idx_sel),
  .iso_upd_en    (iso_upd_en),
  .auto_flush_en (auto_flush_en),
  .ep_cfg        (ep_cfg)
);

// File: tb/usb_epr_top_tb.sv
`timescale 1ns/1ps
module usb_epr_top_tb;
  localparam int NEP = 5;
  localparam int NRG = 5;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [7:0]   bus_addr = '0;
  logic         bus_wr = 1'b0;
  logic [7:0]   bus_wdata = '0;
  logic         bus_rd = 1'b0;
  logic [7:0]   bus_rdata;
  logic         sof_stb = 1'b0;
  logic [10:0]  sof_frame = '0;
  logic         iso_upd_en;
  logic         auto_flush_en;
  logic [NEP*NRG*8-1:0] ep_cfg;

  always #2.5 clk = ~clk;

  usb_epr_top u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .sof_stb(sof_stb), .sof_frame(sof_frame), .iso_upd_en(iso_upd_en),
    .auto_flush_en(auto_flush_en), .ep_cfg(ep_cfg)
  );

  int    vectors = 0;
  int    miscompares = 0;
  string cur_req = "R1";

  // behavioural reference state
  int fn_m, sel_m, iso_m, auto_m, rd_m;
  int ep_m [NEP][NRG];

  function automatic int model_read(int a);
    if (a == 'h56) return fn_m & 'hFF;
    if (a == 'h57) return (fn_m >> 8) & 7;
    if (a == 'h58) return iso_m * 128 + auto_m * 64 + sel_m;
    if (a >= 'h50 && a < 'h50 + NRG && sel_m < NEP) return ep_m[sel_m][a - 'h50];
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      fn_m = 0; sel_m = 0; iso_m = 0; auto_m = 0; rd_m = 0;
      for (int e = 0; e < NEP; e++)
        for (int r = 0; r < NRG; r++) ep_m[e][r] = 0;
    end else begin
      int a;
      a = int'(bus_addr);
      if (bus_rd) rd_m = model_read(a);
      if (bus_wr) begin
        if (a == 'h58) begin
          sel_m  = int'(bus_wdata) & 7;
          auto_m = (int'(bus_wdata) >> 6) & 1;
          iso_m  = (int'(bus_wdata) >> 7) & 1;
        end else if (a >= 'h50 && a < 'h50 + NRG && sel_m < NEP)
          ep_m[sel_m][a - 'h50] = int'(bus_wdata);
      end
      if (sof_stb) fn_m = int'(sof_frame);
    end
  end

  always @(negedge clk) begin
    bit bad;
    bad = 1'b0;
    vectors++;
    if (int'(bus_rdata) != rd_m) begin
      bad = 1'b1;
      $display("FAIL %s rdata actual=%02h expected=%02h", cur_req, bus_rdata, rd_m);
    end
    if (int'(iso_upd_en) != iso_m || int'(auto_flush_en) != auto_m) begin
      bad = 1'b1;
      $display("FAIL %s iso/auto actual=%0d/%0d expected=%0d/%0d",
               cur_req, iso_upd_en, auto_flush_en, iso_m, auto_m);
    end
    for (int e = 0; e < NEP; e++)
      for (int r = 0; r < NRG; r++)
        if (int'(ep_cfg[(e*NRG+r)*8 +: 8]) != ep_m[e][r]) begin
          bad = 1'b1;
          $display("FAIL %s ep_cfg[%0d][%0d] actual=%02h expected=%02h",
                   cur_req, e, r, ep_cfg[(e*NRG+r)*8 +: 8], ep_m[e][r]);
        end
    if (bad) miscompares++;
  end

  task automatic cyc(input bit rd, input bit wr, input int a, input int d,
                     input bit sof, input int f);
    @(negedge clk); #1;
    bus_rd = rd; bus_wr = wr; bus_addr = 8'(a); bus_wdata = 8'(d);
    sof_stb = sof; sof_frame = 11'(f);
  endtask
  task automatic wr(input int a, input int d); cyc(0, 1, a, d, 0, 0); endtask
  task automatic rd(input int a);              cyc(1, 0, a, 0, 0, 0); endtask
  task automatic sof(input int f);             cyc(0, 0, 0, 0, 1, f); endtask
  task automatic idle();                       cyc(0, 0, 0, 0, 0, 0); endtask

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    int lfsr;
    // R1: reset state and every mapped register reads zero
    cur_req = "R1";
    repeat (3) idle();
    cyc(0, 0, 0, 0, 0, 0); rst_n = 1'b1;
    for (int a = 'h50; a <= 'h58; a++) rd(a);
    idle();

    // R2: frame capture across both bytes
    cur_req = "R2";
    sof('h5A3); rd('h56); rd('h57); rd('h57);
    sof('h7FF); rd('h57); rd('h56);
    sof('h000); rd('h56); rd('h57);
    sof('h4C1); idle(); idle(); rd('h57);

    // R3: frame bytes ignore writes, even alongside a strobe
    cur_req = "R3";
    wr('h56, 'hFF); wr('h57, 'hFF); rd('h56); rd('h57);
    cyc(0, 1, 'h57, 'h00, 1, 'h2B6); rd('h57); rd('h56);

    // R4 / R5: index register fields and global outputs
    cur_req = "R4";
    wr('h58, 'hFF); rd('h58); idle();
    wr('h58, 'h38); rd('h58);
    cur_req = "R5";
    wr('h58, 'h80); idle(); wr('h58, 'h40); idle(); wr('h58, 'hC2); rd('h58);

    // R6: each endpoint has its own window bytes
    cur_req = "R6";
    for (int e = 0; e < NEP; e++) begin
      wr('h58, e);
      for (int r = 0; r < NRG; r++) wr('h50 + r, 16 * e + r + 1);
    end
    for (int e = NEP - 1; e >= 0; e--) begin
      wr('h58, e);
      for (int r = 0; r < NRG; r++) rd('h50 + r);
    end

    // R7: undefined selects neither write nor read the window
    cur_req = "R7";
    for (int s = NEP; s < 8; s++) begin
      wr('h58, s);
      for (int r = 0; r < NRG; r++) begin wr('h50 + r, 'hEE); rd('h50 + r); end
    end
    wr('h58, 0); for (int r = 0; r < NRG; r++) rd('h50 + r);

    // R8: unmapped addresses
    cur_req = "R8";
    wr('h00, 'h55); rd('h00); wr('h4F, 'h12); rd('h4F);
    wr('h55, 'h34); rd('h55); wr('h59, 'h56); rd('h59); rd('hFF);

    // R9: read-before-write ordering and hold
    cur_req = "R9";
    wr('h58, 2); cyc(1, 1, 'h51, 'hA5, 0, 0); idle(); idle(); rd('h51);
    cyc(1, 1, 'h58, 'h83, 0, 0); idle(); rd('h58); idle(); idle();

    // mixed traffic across all requirements
    cur_req = "R6";
    lfsr = 'h1ACE;
    for (int i = 0; i < 400; i++) begin
      int op, a;
      lfsr = (lfsr * 1103515245 + 12345) & 'h7FFFFFFF;
      op = (lfsr >> 8) & 7;
      a  = 'h4E + ((lfsr >> 12) % 13);
      cyc(op[0], op[1], a, (lfsr >> 16) & 'hFF, op[2], (lfsr >> 4) & 'h7FF);
    end
    idle(); idle();

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule